// File: doc/BRIEF.md
# DMA Proxy Command Register Front End

This block is the host-facing register front end through which an external controller queues a single DMA command for a local processing unit. The host writes five argument registers: local-store address, effective-address upper word, effective-address lower word, a combined size/tag word, and the command opcode. The block latches each value and records which of the five have been written since the last accepted command.

Writing the opcode does not launch anything. The command is checked and launched only when the host reads the command-status register. If any of the five arguments is missing, the read returns a sequence-error code and nothing changes. If all five are present, the block clears the written record and decodes the opcode. It then raises a one-cycle transfer request carrying the latched arguments, or a one-cycle ordering-fence pulse, or it reports an unrecognized opcode. Transfer opcodes with the start bit set also start the unit, unless the unit is already running.

Top module: `dma_proxy_regif`

## Requirements
- R1: After synchronous active-low reset, `xfer_req`, `fence_pulse`, `start_pulse` and `unit_running` are 0, and a status read returns the sequence-error code 1.
- R2: Register addresses are: status 0x0, local address 0x1, effective-address high 0x2, effective-address low 0x3, size/tag 0x4, opcode 0x5. A status read when any of the five arguments has not been written since the last accepted command returns 1. Such a read issues no pulse and leaves both the written record and the latched arguments unchanged.
- R3: An accepted status read (all five written) clears the written record. An immediately following status read therefore returns 1.
- R4: A size/tag write stores the tag from wdata[4:0] and the size from wdata[30:16]. All other bits are ignored.
- R5: An opcode write keeps only wdata[7:0].
- R6: The put/get opcodes are 0x20, 0x21, 0x22, 0x23, 0x24, 0x25, 0x30, 0x32, 0x34, 0x40, 0x41, 0x42, 0x43, 0x44 and 0x45. Each returns code 0. Each pulses `xfer_req` with the latched opcode, local address, {high,low} effective address, size and tag only when the size is nonzero.
- R7: The send-signal opcodes are 0xA0, 0xA2 and 0xA4. With size 4 they behave as in R6. With any other size they return code 2 and issue no transfer.
- R8: The opcodes 0xC0 (barrier), 0xC8 (eieio) and 0xCC (sync) return code 0, pulse `fence_pulse` and issue no transfer.
- R9: Any other opcode returns code 2 and issues no pulse. The written record is still cleared.
- R10: An accepted put/get opcode with bit 0 set requests a start, whatever its size. If `unit_running` is 0, this pulses `start_pulse` and sets `unit_running`. If `unit_running` is already 1, no pulse occurs. A `unit_halt` input pulse clears `unit_running`.
- R11: `rdata` and every output pulse appear in the cycle after the read-enable cycle, and each pulse lasts exactly one cycle.
- R12: An argument write in the same cycle as a status read takes effect after the check. The current command uses the old value, and the write counts toward the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| waddr | input | 4 | Write address |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| raddr | input | 4 | Read address |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| xfer_req | output | 1 | One-cycle transfer request |
| xfer_opc | output | 8 | Opcode of the issued transfer |
| xfer_lsa | output | 32 | Local-store address of the transfer |
| xfer_ea | output | 64 | Effective address {high, low} |
| xfer_size | output | 15 | Transfer size |
| xfer_tag | output | 5 | Transfer tag |
| fence_pulse | output | 1 | One-cycle ordering-fence pulse |
| start_pulse | output | 1 | One-cycle start of the unit |
| unit_halt | input | 1 | Unit reports it has stopped |
| unit_running | output | 1 | Running status of the unit |

## Verification
The status read is tried in several conditions: with an argument missing, with all five written, repeated straight after an acceptance, and together with an argument write in the same cycle. These separate a check on the written record from a check on the opcode alone. They also show whether clearing happens at acceptance or at the write. The opcode decode is tried with put, get, signal with size 4 and with size 8, the three fence opcodes, an undefined value and a zero size. Each of these leaves a distinct combination of code, transfer pulse and fence pulse. Start requests are issued both while idle and while running, which separates a start that always fires from one that depends on the running status.

// File: rtl/dma_proxy_pkg.sv
// Package dma_proxy_pkg
// Shared widths, register addresses, result codes, opcode tables and the
// argument record for the DMA proxy register front end.
// Assumes a 32-bit register bus with word-granular addresses.
package dma_proxy_pkg;

    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 4;
    localparam int OPC_W      = 8;
    localparam int SIZE_W     = 15;
    localparam int SIZE_LSB   = 16;
    localparam int TAG_W      = 5;
    localparam int ARG_CNT    = 5;
    localparam int EA_W       = 2 * WORD_W;
    localparam int SIGNAL_SIZE = 4;

    // Written-record bit positions
    localparam int ARG_LSA   = 0;
    localparam int ARG_EAL   = 1;
    localparam int ARG_EAH   = 2;
    localparam int ARG_SZTAG = 3;
    localparam int ARG_OPC   = 4;

    // Register addresses
    localparam logic [ADDR_W-1:0] RA_STATUS = 4'h0;
    localparam logic [ADDR_W-1:0] RA_LSA    = 4'h1;
    localparam logic [ADDR_W-1:0] RA_EAH    = 4'h2;
    localparam logic [ADDR_W-1:0] RA_EAL    = 4'h3;
    localparam logic [ADDR_W-1:0] RA_SZTAG  = 4'h4;
    localparam logic [ADDR_W-1:0] RA_OPC    = 4'h5;

    // Status read result codes
    localparam logic [WORD_W-1:0] ST_OK      = 32'd0;
    localparam logic [WORD_W-1:0] ST_SEQ_ERR = 32'd1;
    localparam logic [WORD_W-1:0] ST_BAD_OPC = 32'd2;

    // Start request bit within the opcode
    localparam int START_BIT = 0;

    // Put/get opcode table
    localparam int N_XFER = 15;
    localparam logic [N_XFER*OPC_W-1:0] XFER_TAB = {
        8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25,
        8'h30, 8'h32, 8'h34,
        8'h40, 8'h41, 8'h42, 8'h43, 8'h44, 8'h45
    };

    // Send-signal opcode table
    localparam int N_SIG = 3;
    localparam logic [N_SIG*OPC_W-1:0] SIG_TAB = {8'hA0, 8'hA2, 8'hA4};

    // Ordering opcode table (barrier, eieio, sync)
    localparam int N_FENCE = 3;
    localparam logic [N_FENCE*OPC_W-1:0] FENCE_TAB = {8'hC0, 8'hC8, 8'hCC};

    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_XFER  = 2'd1,
        K_FENCE = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        logic [WORD_W-1:0] lsa;
        logic [WORD_W-1:0] eah;
        logic [WORD_W-1:0] eal;
        logic [SIZE_W-1:0] size;
        logic [TAG_W-1:0]  tag;
        logic [OPC_W-1:0]  opc;
    } cmd_args_t;

endpackage

// File: rtl/dma_proxy_argbank.sv
// Module dma_proxy_argbank
// Latches the five command arguments and keeps the written record, one
// bit per argument. A write sets its bit. A clear request from an accepted
// status read resets the record, but a write in the same cycle wins, so
// that write counts toward the next command.
// Assumes wr_hit is one-hot or zero.
module dma_proxy_argbank
    import dma_proxy_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ARG_CNT-1:0]          wr_hit,
    input  logic [WORD_W-1:0]           wdata,
    input  logic                        clear_rec,
    output cmd_args_t                   args,
    output logic [ARG_CNT-1:0]          written
);

    // One written-record bit per argument
    for (genvar i = 0; i < ARG_CNT; i++) begin : g_rec
        // Set on write, clear on acceptance, write has priority
        always_ff @(posedge clk) begin
            if (!rst_n)
                written[i] <= 1'b0;
            else if (wr_hit[i])
                written[i] <= 1'b1;
            else if (clear_rec)
                written[i] <= 1'b0;
        end
    end

    // Local-store address latch
    always_ff @(posedge clk) begin
        if (!rst_n)
            args.lsa <= '0;
        else if (wr_hit[ARG_LSA])
            args.lsa <= wdata;
    end

    // Effective-address upper word latch
    always_ff @(posedge clk) begin
        if (!rst_n)
            args.eah <= '0;
        else if (wr_hit[ARG_EAH])
            args.eah <= wdata;
    end

    // Effective-address lower word latch
    always_ff @(posedge clk) begin
        if (!rst_n)
            args.eal <= '0;
        else if (wr_hit[ARG_EAL])
            args.eal <= wdata;
    end

    // Size and tag fields from one word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            args.size <= '0;
            args.tag  <= '0;
        end else if (wr_hit[ARG_SZTAG]) begin
            args.size <= wdata[SIZE_LSB +: SIZE_W];
            args.tag  <= wdata[TAG_W-1:0];
        end
    end

    // Opcode latch, low byte only
    always_ff @(posedge clk) begin
        if (!rst_n)
            args.opc <= '0;
        else if (wr_hit[ARG_OPC])
            args.opc <= wdata[OPC_W-1:0];
    end

endmodule

// File: rtl/dma_proxy_decode.sv
// Module dma_proxy_decode
// Classifies a latched opcode against the put/get, send-signal and ordering
// tables. Send-signal opcodes count as transfers only with size 4. It also
// flags a start request for transfer opcodes with the start bit set.
// Purely combinational.
module dma_proxy_decode
    import dma_proxy_pkg::*;
(
    input  logic [OPC_W-1:0]  opc,
    input  logic [SIZE_W-1:0] size,
    output cmd_kind_e         kind,
    output logic              start_req
);

    logic hit_xfer;
    logic hit_sig;
    logic hit_fence;

    // Table lookups
    always_comb begin
        hit_xfer  = 1'b0;
        hit_sig   = 1'b0;
        hit_fence = 1'b0;
        for (int i = 0; i < N_XFER; i++)
            if (opc == XFER_TAB[i*OPC_W +: OPC_W]) hit_xfer = 1'b1;
        for (int i = 0; i < N_SIG; i++)
            if (opc == SIG_TAB[i*OPC_W +: OPC_W]) hit_sig = 1'b1;
        for (int i = 0; i < N_FENCE; i++)
            if (opc == FENCE_TAB[i*OPC_W +: OPC_W]) hit_fence = 1'b1;
    end

    // Kind selection and start request
    always_comb begin
        if (hit_xfer || (hit_sig && size == SIZE_W'(SIGNAL_SIZE)))
            kind = K_XFER;
        else if (hit_fence)
            kind = K_FENCE;
        else
            kind = K_NONE;
        start_req = (kind == K_XFER) && opc[START_BIT];
    end

endmodule

// File: rtl/dma_proxy_runctl.sv
// Module dma_proxy_runctl
// Holds the running status of the unit. A start request pulses start_out
// and sets running only from the idle state. A halt from the unit clears
// running.
module dma_proxy_runctl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic halt,
    output logic running,
    output logic start_out
);

    // Running status and one-cycle start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            start_out <= 1'b0;
        end else begin
            start_out <= start_req && !running;
            if (start_req && !running)
                running <= 1'b1;
            else if (halt)
                running <= 1'b0;
        end
    end

endmodule

// File: rtl/dma_proxy_regif.sv
// Module dma_proxy_regif
// Register front end that queues one DMA proxy command. Arguments are
// latched on write. A read of the status register checks the written
// record, decodes the opcode and issues a transfer or fence pulse or an
// error code. Read data and pulses are registered and appear the cycle
// after the read strobe.
// Assumes separate read and write addresses on a single-cycle bus.
module dma_proxy_regif
    import dma_proxy_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   waddr,
    input  logic [WORD_W-1:0]   wdata,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   raddr,
    output logic [WORD_W-1:0]   rdata,
    output logic                xfer_req,
    output logic [OPC_W-1:0]    xfer_opc,
    output logic [WORD_W-1:0]   xfer_lsa,
    output logic [EA_W-1:0]     xfer_ea,
    output logic [SIZE_W-1:0]   xfer_size,
    output logic [TAG_W-1:0]    xfer_tag,
    output logic                fence_pulse,
    output logic                start_pulse,
    input  logic                unit_halt,
    output logic                unit_running
);

    logic [ARG_CNT-1:0] wr_hit;
    logic [ARG_CNT-1:0] written;
    cmd_args_t          args;
    cmd_kind_e          kind;
    logic               dec_start;
    logic               status_rd;
    logic               accept;
    logic               issue_xfer;

    // Write address to argument one-hot decode
    always_comb begin
        wr_hit = '0;
        if (wr_en) begin
            case (waddr)
                RA_LSA:   wr_hit[ARG_LSA]   = 1'b1;
                RA_EAH:   wr_hit[ARG_EAH]   = 1'b1;
                RA_EAL:   wr_hit[ARG_EAL]   = 1'b1;
                RA_SZTAG: wr_hit[ARG_SZTAG] = 1'b1;
                RA_OPC:   wr_hit[ARG_OPC]   = 1'b1;
                default:  wr_hit = '0;
            endcase
        end
    end

    // Acceptance condition on a status read
    always_comb begin
        status_rd  = rd_en && (raddr == RA_STATUS);
        accept     = status_rd && (&written);
        issue_xfer = accept && (kind == K_XFER) && (args.size != '0);
    end

    dma_proxy_argbank u_argbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_hit),
        .wdata     (wdata),
        .clear_rec (accept),
        .args      (args),
        .written   (written)
    );

    dma_proxy_decode u_decode (
        .opc       (args.opc),
        .size      (args.size),
        .kind      (kind),
        .start_req (dec_start)
    );

    dma_proxy_runctl u_runctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (accept && dec_start),
        .halt      (unit_halt),
        .running   (unit_running),
        .start_out (start_pulse)
    );

    // Registered read data with result code
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (status_rd && !accept)
            rdata <= ST_SEQ_ERR;
        else if (accept)
            rdata <= (kind == K_NONE) ? ST_BAD_OPC : ST_OK;
        else
            rdata <= '0;
    end

    // One-cycle transfer and fence pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_req    <= 1'b0;
            fence_pulse <= 1'b0;
        end else begin
            xfer_req    <= issue_xfer;
            fence_pulse <= accept && (kind == K_FENCE);
        end
    end

    // Transfer payload captured on issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_opc  <= '0;
            xfer_lsa  <= '0;
            xfer_ea   <= '0;
            xfer_size <= '0;
            xfer_tag  <= '0;
        end else if (issue_xfer) begin
            xfer_opc  <= args.opc;
            xfer_lsa  <= args.lsa;
            xfer_ea   <= {args.eah, args.eal};
            xfer_size <= args.size;
            xfer_tag  <= args.tag;
        end
    end

endmodule

// File: rtl/dma_proxy_regif_chk.sv
// Module dma_proxy_regif_chk
// Property checker bound to dma_proxy_regif. It watches the bus, the written
// record and the output pulses.
module dma_proxy_regif_chk
    import dma_proxy_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   raddr,
    input logic [WORD_W-1:0]   rdata,
    input logic [ARG_CNT-1:0]  written,
    input logic                xfer_req,
    input logic [SIZE_W-1:0]   xfer_size,
    input logic                fence_pulse,
    input logic                start_pulse,
    input logic                unit_running
);

    a_r2_seq_error: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && raddr == RA_STATUS && written != '1)
        |=> (rdata == ST_SEQ_ERR && !xfer_req && !fence_pulse && !start_pulse));

    a_r3_record_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && raddr == RA_STATUS && written == '1 && !wr_en)
        |=> (written == '0));

    a_r6_nonzero_size: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> (xfer_size != '0));

    a_r8_exclusive_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xfer_req, fence_pulse}));

    a_r10_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $rose(unit_running));

    a_r11_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |=> !xfer_req);

endmodule

bind dma_proxy_regif dma_proxy_regif_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .raddr        (raddr),
    .rdata        (rdata),
    .written      (written),
    .xfer_req     (xfer_req),
    .xfer_size    (xfer_size),
    .fence_pulse  (fence_pulse),
    .start_pulse  (start_pulse),
    .unit_running (unit_running)
);

// File: tb/dma_proxy_regif_bench.sv
// Directed bench for dma_proxy_regif: one task per scenario.
module dma_proxy_regif_bench;
    import dma_proxy_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  waddr = '0;
    logic [31:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  raddr = '0;
    logic [31:0] rdata;
    logic        xfer_req;
    logic [7:0]  xfer_opc;
    logic [31:0] xfer_lsa;
    logic [63:0] xfer_ea;
    logic [14:0] xfer_size;
    logic [4:0]  xfer_tag;
    logic        fence_pulse;
    logic        start_pulse;
    logic        unit_halt = 1'b0;
    logic        unit_running;

    int checks = 0;
    int errors = 0;

    // Values captured one cycle after a status read, and one cycle later
    logic [31:0] c_rdata;
    logic        c_xfer, c_fence, c_start, c_run;
    logic [7:0]  c_opc;
    logic [31:0] c_lsa;
    logic [63:0] c_ea;
    logic [14:0] c_size;
    logic [4:0]  c_tag;
    logic        n_xfer, n_fence, n_start;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_proxy_regif u_dma_proxy_regif (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .waddr        (waddr),
        .wdata        (wdata),
        .rd_en        (rd_en),
        .raddr        (raddr),
        .rdata        (rdata),
        .xfer_req     (xfer_req),
        .xfer_opc     (xfer_opc),
        .xfer_lsa     (xfer_lsa),
        .xfer_ea      (xfer_ea),
        .xfer_size    (xfer_size),
        .xfer_tag     (xfer_tag),
        .fence_pulse  (fence_pulse),
        .start_pulse  (start_pulse),
        .unit_halt    (unit_halt),
        .unit_running (unit_running)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; waddr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic capture();
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        c_rdata = rdata; c_xfer = xfer_req; c_fence = fence_pulse;
        c_start = start_pulse; c_run = unit_running; c_opc = xfer_opc;
        c_lsa = xfer_lsa; c_ea = xfer_ea; c_size = xfer_size; c_tag = xfer_tag;
        @(negedge clk);
        n_xfer = xfer_req; n_fence = fence_pulse; n_start = start_pulse;
    endtask

    task automatic rd_status();
        rd_en = 1'b1; raddr = RA_STATUS;
        capture();
    endtask

    task automatic load(input logic [31:0] lsa, input logic [31:0] eah, input logic [31:0] eal,
                        input logic [31:0] sztag, input logic [31:0] opc);
        wr(RA_LSA, lsa); wr(RA_EAH, eah); wr(RA_EAL, eal);
        wr(RA_SZTAG, sztag); wr(RA_OPC, opc);
    endtask

    task automatic t_reset();
        check("R1 xfer_req", xfer_req, 0);
        check("R1 fence", fence_pulse, 0);
        check("R1 start", start_pulse, 0);
        check("R1 running", unit_running, 0);
        rd_status();
        check("R1 status after reset", c_rdata, 1);
    endtask

    task automatic t_missing();
        wr(RA_LSA, 32'h1111_0000); wr(RA_EAH, 32'h0000_00AA);
        wr(RA_EAL, 32'h2222_0000); wr(RA_SZTAG, 32'h0080_0003);
        rd_status();
        check("R2 missing opcode code", c_rdata, 1);
        check("R2 missing opcode no xfer", c_xfer, 0);
        wr(RA_OPC, 32'h20);
        rd_status();
        check("R6 put code", c_rdata, 0);
        check("R6 put xfer", c_xfer, 1);
        check("R2 args kept lsa", c_lsa, 64'h1111_0000);
        check("R2 args kept ea", c_ea, 64'h0000_00AA_2222_0000);
        check("R6 size", c_size, 15'h80);
        check("R6 tag", c_tag, 3);
        check("R6 opc", c_opc, 8'h20);
        check("R11 xfer one cycle", n_xfer, 0);
    endtask

    task automatic t_clear();
        rd_status();
        check("R3 reread seq error", c_rdata, 1);
        check("R3 reread no xfer", c_xfer, 0);
    endtask

    task automatic t_fields();
        load(32'h5, 32'h6, 32'h7, 32'hFFFF_FFFF, 32'hABCD_0040);
        rd_status();
        check("R4 size field", c_size, 15'h7FFF);
        check("R4 tag field", c_tag, 5'h1F);
        check("R5 opcode low byte", c_opc, 8'h40);
        check("R5 get accepted", c_rdata, 0);
    endtask

    task automatic t_zero_size();
        load(32'h1, 32'h2, 32'h3, 32'h0000_0007, 32'h44);
        rd_status();
        check("R6 zero size code", c_rdata, 0);
        check("R6 zero size no xfer", c_xfer, 0);
    endtask

    task automatic t_signal();
        load(32'h10, 32'h0, 32'h20, 32'h0004_0001, 32'hA2);
        rd_status();
        check("R7 signal size4 code", c_rdata, 0);
        check("R7 signal size4 xfer", c_xfer, 1);
        load(32'h10, 32'h0, 32'h20, 32'h0008_0001, 32'hA0);
        rd_status();
        check("R7 signal size8 code", c_rdata, 2);
        check("R7 signal size8 no xfer", c_xfer, 0);
    endtask

    task automatic t_fence();
        logic [7:0] ops [3] = '{8'hC0, 8'hC8, 8'hCC};
        for (int i = 0; i < 3; i++) begin
            load(32'h0, 32'h0, 32'h0, 32'h0010_0000, {24'h0, ops[i]});
            rd_status();
            check("R8 fence code", c_rdata, 0);
            check("R8 fence pulse", c_fence, 1);
            check("R8 fence no xfer", c_xfer, 0);
            check("R11 fence one cycle", n_fence, 0);
        end
    endtask

    task automatic t_unknown();
        load(32'h0, 32'h0, 32'h0, 32'h0010_0000, 32'h77);
        rd_status();
        check("R9 unknown code", c_rdata, 2);
        check("R9 unknown no pulse", {c_xfer, c_fence, c_start}, 0);
        rd_status();
        check("R9 record cleared", c_rdata, 1);
    endtask

    task automatic t_start();
        load(32'h0, 32'h0, 32'h40, 32'h0010_0000, 32'h21);
        rd_status();
        check("R10 start pulse", c_start, 1);
        check("R10 running set", c_run, 1);
        check("R10 start one cycle", n_start, 0);
        load(32'h0, 32'h0, 32'h40, 32'h0010_0000, 32'h41);
        rd_status();
        check("R10 no start while running", c_start, 0);
        check("R10 still running", c_run, 1);
        unit_halt = 1'b1;
        @(negedge clk);
        unit_halt = 1'b0;
        check("R10 halt clears", unit_running, 0);
        load(32'h0, 32'h0, 32'h40, 32'h0000_0000, 32'h23);
        rd_status();
        check("R10 start with zero size", c_start, 1);
        check("R10 zero size no xfer", c_xfer, 0);
        unit_halt = 1'b1;
        @(negedge clk);
        unit_halt = 1'b0;
    endtask

    task automatic t_same_cycle();
        load(32'hAAAA, 32'h0, 32'h1, 32'h0020_0002, 32'h42);
        rd_en = 1'b1; raddr = RA_STATUS;
        wr_en = 1'b1; waddr = RA_LSA; wdata = 32'hBBBB;
        capture();
        check("R12 old lsa used", c_lsa, 64'hAAAA);
        check("R12 accepted", c_rdata, 0);
        rd_status();
        check("R12 only lsa recorded", c_rdata, 1);
        wr(RA_EAH, 32'h0); wr(RA_EAL, 32'h1); wr(RA_SZTAG, 32'h0020_0002); wr(RA_OPC, 32'h42);
        rd_status();
        check("R12 next command accepted", c_rdata, 0);
        check("R12 new lsa used", c_lsa, 64'hBBBB);
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_missing();
        t_clear();
        t_fields();
        t_zero_size();
        t_signal();
        t_fence();
        t_unknown();
        t_start();
        t_same_cycle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule